// File: doc/BRIEF.md
# SD card clock divider

This block derives the SD card clock from a faster peripheral clock. The division factor is the product of two cascaded stages: a power-of-two prescaler and a linear divisor from 1 to 16. Software sets both through a single system-control register write port. The same register also carries the exponent of the data-timeout counter. A separate enable input gates the card clock. The gate stops the clock only on a low phase, so no shortened high pulse reaches the card.

The divider fields can only be rewritten while the enable is low and the card clock has come to rest. A write made at any other time keeps the old divider settings, but the timeout exponent in the same write still takes effect. Once the enable is set, a stable flag rises after a fixed number of input-clock cycles. Software waits for this flag before it uses the new frequency. The flag drops in the same cycle that the enable is cleared.

The timeout unit counts completed card-clock periods during which there is no data activity. It raises a sticky flag once a power-of-two threshold is reached. The exponent field selects that threshold.

Top module: `sdclk_gen`

## Requirements
- R1: Register fields: the timeout exponent is taken from bits 19:16, the prescale field from bits 15:8 and the linear field from bits 7:4. The prescale multiplier is 1 when the field is zero, and otherwise twice the weight of its highest set bit (0x01 gives 2, 0x80 gives 256). The linear multiplier is the field value plus one. The division factor is the product of the two multipliers.
- R2: While running, the card clock has a period of exactly the division factor in input cycles. It is high for the floor of half the factor and low for the rest. A factor of 1 is produced as a factor of 2. The first high phase starts at the first input edge that samples the enable high.
- R3: The card clock is low whenever it is stopped. After the enable is cleared, an ongoing high phase runs to its full length, and the clock stops at the first edge that finds it in its low phase.
- R4: A write while the enable is high or the card clock is still running leaves the division factor unchanged. The exponent field of that write is still applied.
- R5: The stable flag rises after 64 input edges that each sample the enable high. It is low in any cycle in which the enable is low.
- R6: The timeout flag rises once 2^(13+exponent) card-clock periods have completed since the last data activity.
- R7: A cycle with data activity clears both the timeout flag and its period count. Without data activity the flag stays set, even if the exponent is later raised.
- R8: After reset, the card clock, the stable flag and the timeout flag are low, and all register fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Write strobe for the system-control register |
| ctl_wdata_i | input | 32 | Write data: exponent, prescale and linear fields |
| clk_en_i | input | 1 | Card clock enable gate |
| data_active_i | input | 1 | Data activity; restarts the timeout count |
| card_clk_o | output | 1 | Divided card clock |
| clk_stable_o | output | 1 | Card clock is stable and may be used |
| data_timeout_o | output | 1 | Sticky data-timeout flag |

## Verification
Two situations can collide in a single cycle. In the first, a register write lands while the enable has just fallen but the clock is still finishing its high phase. In the second, a data-activity pulse arrives on the same edge as the card-clock period that would reach the timeout threshold. Random stimulus with a fixed seed drops writes and activity pulses at arbitrary cycles, including right after the enable falls, so both collisions occur many times. A per-cycle model derived from the requirements judges every cycle: a colliding write must leave the period unchanged while its exponent takes effect, and the activity pulse must win over the threshold so the flag stays low. Directed cases pin down the exact period for chosen factors, the full-length last high pulse and the timeout onset.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // Field positions in the system-control register word.
  localparam int LDIV_LSB = 4;
  localparam int PRE_LSB  = 8;
  localparam int EXP_LSB  = 16;
endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg
  import sdclk_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int PRE_W  = 8,
  parameter int LDIV_W = 4,
  parameter int EXP_W  = 4,
  parameter int FACT_W = PRE_W + 1 + LDIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              div_open_i,
  input  logic              run_i,
  output logic [FACT_W-1:0] factor_o,
  output logic [EXP_W-1:0]  exp_o
);
  logic [PRE_W-1:0]  pre_q, pre_n;
  logic [LDIV_W-1:0] ldiv_q, ldiv_n;
  logic [EXP_W-1:0]  exp_q, exp_n;
  logic [FACT_W-1:0] pre_mult, raw_fact;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata_i[REG_W-1:EXP_LSB+EXP_W], wdata_i[LDIV_LSB-1:0]};

  always_comb begin
    pre_n  = pre_q;
    ldiv_n = ldiv_q;
    exp_n  = exp_q;
    if (we_i) begin
      exp_n = wdata_i[EXP_LSB +: EXP_W];
      if (div_open_i) begin
        pre_n  = wdata_i[PRE_LSB +: PRE_W];
        ldiv_n = wdata_i[LDIV_LSB +: LDIV_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      ldiv_q <= '0;
      exp_q  <= '0;
    end else if (we_i) begin
      pre_q  <= pre_n;
      ldiv_q <= ldiv_n;
      exp_q  <= exp_n;
    end
  end

  // Highest set prescale bit selects the power of two.
  always_comb begin
    pre_mult = FACT_W'(1);
    for (int i = 0; i < PRE_W; i++) begin
      if (pre_q[i]) pre_mult = FACT_W'(2) << i;
    end
    raw_fact = pre_mult * (FACT_W'(ldiv_q) + FACT_W'(1));
    factor_o = (raw_fact < FACT_W'(2)) ? FACT_W'(2) : raw_fact;
  end

  assign exp_o = exp_q;

  AST_DIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(factor_o)); // R4

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
  parameter int FACT_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FACT_W-1:0] factor_i,
  output logic              card_clk_o,
  output logic              run_o,
  output logic              tick_o
);
  logic [FACT_W-1:0] cnt_q, cnt_n, half, last;
  logic              run_q, run_n, clk_q, clk_n;

  assign half = factor_i >> 1;
  assign last = factor_i - FACT_W'(1);

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    if (!run_q) begin
      run_n = en_i;
      cnt_n = '0;
    end else if (!en_i && (cnt_q >= half)) begin
      run_n = 1'b0;
      cnt_n = '0;
    end else begin
      cnt_n = (cnt_q == last) ? '0 : cnt_q + FACT_W'(1);
    end
    clk_n = run_n && (cnt_n < half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
      clk_q <= clk_n;
    end
  end

  assign card_clk_o = clk_q;
  assign run_o      = run_q;
  assign tick_o     = run_q && (cnt_q == last);

  AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_q) |-> (run_q && cnt_q == half)); // R3
  AST_GATED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !clk_q); // R3
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < factor_i)); // R2

endmodule

// File: rtl/sdclk_stable.sv
module sdclk_stable #(
  parameter int STABLE_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic stable_o
);
  localparam int SW = $clog2(STABLE_CYCLES + 1);

  logic [SW-1:0] cnt_q, cnt_n;
  logic          done;

  assign done = (cnt_q == SW'(STABLE_CYCLES));

  always_comb begin
    if (!en_i)     cnt_n = '0;
    else if (done) cnt_n = cnt_q;
    else           cnt_n = cnt_q + SW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  assign stable_o = en_i && done;

  AST_STABLE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stable_o) |-> $past(en_i)); // R5
  AST_STABLE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/sdclk_timeout.sv
module sdclk_timeout #(
  parameter int EXP_W   = 4,
  parameter int TO_BASE = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             dto_o
);
  localparam int TO_W = TO_BASE + (1 << EXP_W);

  logic [TO_W-1:0] cnt_q, cnt_n, limit;
  logic            dto_q, dto_n;

  assign limit = TO_W'(1) << (TO_BASE + int'(exp_i));

  always_comb begin
    if (active_i)                    cnt_n = '0;
    else if (tick_i && cnt_q < limit) cnt_n = cnt_q + TO_W'(1);
    else                             cnt_n = cnt_q;
    dto_n = !active_i && (dto_q || (cnt_n >= limit));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dto_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dto_q <= dto_n;
    end
  end

  assign dto_o = dto_q;

  AST_TO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |=> !dto_o); // R7
  AST_TO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dto_o && !active_i) |=> dto_o); // R7
  AST_TO_ONSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dto_o) |-> (cnt_q != '0)); // R6

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int REG_W         = 32,
  parameter int PRE_W         = 8,
  parameter int LDIV_W        = 4,
  parameter int EXP_W         = 4,
  parameter int TO_BASE       = 13,
  parameter int STABLE_CYCLES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  input  logic             clk_en_i,
  input  logic             data_active_i,
  output logic             card_clk_o,
  output logic             clk_stable_o,
  output logic             data_timeout_o
);
  localparam int FACT_W = PRE_W + 1 + LDIV_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              run, tick, div_open;
  logic [FACT_W-1:0] factor;
  logic [EXP_W-1:0]  dto_exp;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign div_open = !clk_en_i && !run;

  sdclk_cfg #(
    .REG_W (REG_W),
    .PRE_W (PRE_W),
    .LDIV_W(LDIV_W),
    .EXP_W (EXP_W),
    .FACT_W(FACT_W)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_wdata_i),
    .div_open_i(div_open),
    .run_i     (run),
    .factor_o  (factor),
    .exp_o     (dto_exp)
  );

  sdclk_div #(
    .FACT_W(FACT_W)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (clk_en_i),
    .factor_i  (factor),
    .card_clk_o(card_clk_o),
    .run_o     (run),
    .tick_o    (tick)
  );

  sdclk_stable #(
    .STABLE_CYCLES(STABLE_CYCLES)
  ) u_stable (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .en_i    (clk_en_i),
    .stable_o(clk_stable_o)
  );

  sdclk_timeout #(
    .EXP_W  (EXP_W),
    .TO_BASE(TO_BASE)
  ) u_timeout (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .active_i(data_active_i),
    .exp_i   (dto_exp),
    .dto_o   (data_timeout_o)
  );

endmodule

// File: tb/test_sdclk_gen.sv
module test_sdclk_gen;
  localparam int STABLE = 64;
  localparam int BASE   = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        en = 1'b0;
  logic        act = 1'b0;
  logic        card, stable, dto;

  int  nchk = 0;
  int  nfail = 0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;

  // Bench model state
  logic [7:0] m_pre;
  logic [3:0] m_ld, m_ex;
  bit         m_run, m_dto;
  int         m_cnt, m_stab, m_to;

  always #2 clk = ~clk;

  sdclk_gen i_sdclk_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ctl_we_i      (we),
    .ctl_wdata_i   (wdata),
    .clk_en_i      (en),
    .data_active_i (act),
    .card_clk_o    (card),
    .clk_stable_o  (stable),
    .data_timeout_o(dto)
  );

  function automatic int f_factor(logic [7:0] pre, logic [3:0] ld);
    int m = 1;
    for (int i = 0; i < 8; i++) if (pre[i]) m = 2 << i;
    m = m * (int'(ld) + 1);
    return (m < 2) ? 2 : m;
  endfunction

  task automatic chk(string req, logic actv, logic expv);
    nchk++;
    if (actv !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, actv, expv, $time);
    end
  endtask

  task automatic chk_int(string req, int actv, int expv);
    nchk++;
    if (actv != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actv, expv, $time);
    end
  endtask

  // Cycle model derived from the requirements
  always @(posedge clk) begin : mdl
    int n, lim;
    bit tk;
    if (!rst_n) begin
      m_pre = '0; m_ld = '0; m_ex = '0;
      m_run = 0; m_cnt = 0; m_stab = 0; m_to = 0; m_dto = 0;
    end else begin
      n   = f_factor(m_pre, m_ld);
      lim = 1 << (BASE + int'(m_ex));
      tk  = m_run && (m_cnt == n - 1);
      if (act) m_to = 0;
      else if (tk && m_to < lim) m_to++;
      m_dto = !act && (m_dto || m_to >= lim);
      if (we) begin
        m_ex = wdata[19:16];
        if (!en && !m_run) begin
          m_pre = wdata[15:8];
          m_ld  = wdata[7:4];
        end
      end
      if (!m_run) begin
        m_run = en; m_cnt = 0;
      end else if (!en && m_cnt >= n / 2) begin
        m_run = 0; m_cnt = 0;
      end else begin
        m_cnt = (m_cnt == n - 1) ? 0 : m_cnt + 1;
      end
      if (!en) m_stab = 0;
      else if (m_stab < STABLE) m_stab++;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      chk("R2 card clock", card, m_run && (m_cnt < f_factor(m_pre, m_ld) / 2));
      chk("R5 stable", stable, en && (m_stab == STABLE));
      chk("R6 timeout", dto, m_dto);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_cfg(logic [7:0] pre, logic [3:0] ld, logic [3:0] ex);
    we = 1'b1;
    wdata = {12'h000, ex, pre, ld, 4'h0};
    tick();
    we = 1'b0;
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    prev = card;
    forever begin
      @(negedge clk);
      if (card && !prev) break;
      prev = card;
    end
    hi = 1;
    forever begin
      @(negedge clk);
      if (!card) break;
      hi++;
    end
    per = hi + 1;
    forever begin
      @(negedge clk);
      if (card) break;
      per++;
    end
    tick();
  endtask

  task automatic stop_clock();
    en = 1'b0;
    repeat (4200) begin
      tick();
      if (!card) break;
    end
    repeat (4100) tick();
  endtask

  task automatic check_factor(logic [7:0] pre, logic [3:0] ld, int expn);
    int per, hi;
    write_cfg(pre, ld, 4'hF);
    en = 1'b1;
    measure(per, hi);
    chk_int("R1 factor period", per, expn);
    chk_int("R2 high phase", hi, expn / 2);
    en = 1'b0;
    repeat (expn + 2) tick();
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin : stim
    int per, hi;
    void'($urandom(32'h5d1c0a7));
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    mon_on = 1'b1;
    // R8: reset state
    chk("R8 card low", card, 1'b0);
    chk("R8 stable low", stable, 1'b0);
    chk("R8 timeout low", dto, 1'b0);
    // R8/R2: zero fields give factor 1, produced as 2
    en = 1'b1;
    measure(per, hi);
    chk_int("R8 reset factor", per, 2);
    en = 1'b0;
    repeat (4) tick();

    // R1: field decoding
    check_factor(8'h00, 4'd2, 3);
    check_factor(8'h01, 4'd0, 2);
    check_factor(8'h04, 4'd2, 24);
    check_factor(8'h05, 4'd0, 8);
    check_factor(8'h80, 4'd0, 256);
    check_factor(8'h02, 4'd15, 64);

    // R5: stable timing
    en = 1'b1;
    repeat (STABLE - 1) tick();
    chk("R5 not yet stable", stable, 1'b0);
    tick();
    chk("R5 stable after count", stable, 1'b1);
    en = 1'b0;
    #0.5;
    chk("R5 drops at once", stable, 1'b0);
    repeat (300) tick();

    // R3: last high phase runs full length
    write_cfg(8'h02, 4'd1, 4'hF);
    en = 1'b1;
    begin : runt
      logic prev;
      prev = card;
      forever begin
        @(negedge clk);
        if (card && !prev) break;
        prev = card;
      end
      hi = 1;
      @(posedge clk); #1;
      en = 1'b0;
      forever begin
        @(negedge clk);
        if (!card) break;
        hi++;
      end
    end
    chk_int("R3 final high phase", hi, 4);
    repeat (20) tick();
    chk("R3 stopped low", card, 1'b0);

    // R4 + R6 + R7: exponent taken while running, divider ignored
    write_cfg(8'h00, 4'd1, 4'hF);
    en = 1'b1;
    tick();
    write_cfg(8'h10, 4'd7, 4'h0);
    measure(per, hi);
    chk_int("R4 divider unchanged", per, 2);
    repeat (16000) tick();
    chk("R6 before threshold", dto, 1'b0);
    repeat (600) tick();
    chk("R6 after threshold", dto, 1'b1);
    write_cfg(8'h00, 4'd0, 4'hF);
    chk("R7 sticky after exponent raise", dto, 1'b1);
    act = 1'b1;
    tick();
    act = 1'b0;
    chk("R7 cleared by activity", dto, 1'b0);
    stop_clock();
    write_cfg(8'h00, 4'd2, 4'h0);
    en = 1'b1;
    measure(per, hi);
    chk_int("R4 accepted when stopped", per, 3);
    en = 1'b0;
    repeat (8) tick();

    // Random phase, judged per cycle by the model
    for (int it = 0; it < 40; it++) begin
      int r;
      logic [7:0] p;
      r = int'($urandom % 8);
      if (r == 0) p = 8'h00;
      else if (r < 6) p = 8'h01 << (r - 1);
      else p = 8'($urandom);
      write_cfg(p, 4'($urandom), 4'($urandom % 2));
      en = 1'b1;
      repeat (50 + $urandom % 400) begin
        act = ($urandom % 40) == 0;
        if (($urandom % 60) == 0) write_cfg(8'($urandom), 4'($urandom), 4'($urandom % 2));
        else tick();
      end
      act = 1'b0;
      en = 1'b0;
      if (($urandom % 2) == 0) write_cfg(8'($urandom % 4), 4'($urandom), 4'h0);
      repeat ($urandom % 30) begin
        act = ($urandom % 20) == 0;
        tick();
      end
      act = 1'b0;
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule